// File: doc/BRIEF.md
# Four-Cell Ending Switching Block

This block is the final stage of a shortened tree mismatch-shaping encoder for a multibit converter. It receives a count from 0 to 4 and turns on exactly that many of four unit cells. Which cells it turns on is chosen so that three difference sequences are pushed out of the signal band. The three sequences are the upper-pair split, the lower-pair split and the split between the pairs. A single prioritised decision table replaces two tree layers. That table compares three loop-filter outputs against two thresholds, so a difference sequence can be non-zero even when the count is even.

Each difference sequence is fed, negated, into its own cascade of two resonators with transfer function −z⁻²/(1+z⁻²). Every filter register is six bits signed and saturates. The decision is combinational from the filter state, the count and the thresholds. The chosen pattern is registered and appears one clock later. The count is sorted into five classes: none, one, two, three and all. For each clock the class picks which branch of the table is used. There is no other sequential control.

Top module: `esb_four_cell`

## Requirements
- R1: After every clock edge out of reset, `cell_sel` holds exactly min(`cell_count`, 4) ones, where `cell_count` is the value sampled at that edge (one cycle of latency).
- R2: A count of 0 gives `cell_sel` = 4'b0000. A count of 4 or more (5 to 7 are clamped) gives 4'b1111. `cell_sel[3]` is cell 1 and `cell_sel[0]` is cell 4.
- R3: For a count of 2, `loop_split` ≥ `thr_far` gives 1100 and `loop_split` < −`thr_far` gives 0011. Otherwise the pattern follows the signs of (`loop_upper`, `loop_lower`): (≥0,≥0) gives 1010, (≥0,<0) gives 1001, (<0,≥0) gives 0110 and (<0,<0) gives 0101.
- R4: For a count of 1, with "in band" meaning −`thr_near` ≤ v < `thr_near`, the first matching row wins:
  - split ≥ −far and upper ≥ near gives 1000.
  - split ≥ 0, upper ≥ 0 and lower in band gives 1000.
  - split < −far and upper < −near gives 0100.
  - split ≥ 0, upper < 0 and lower in band gives 0100.
  - upper in band and lower ≥ near gives 0010.
  - split < 0, upper in band and lower ≥ 0 gives 0010.
  - upper in band and lower < −near gives 0001.
  - split < 0, upper in band and lower < 0 gives 0001.
- R5: For a count of 3, the first matching row wins:
  - upper in band and lower ≥ near gives 1110.
  - split ≥ 0, upper in band and lower ≥ 0 gives 1110.
  - upper in band and lower < −near gives 1101.
  - split ≥ 0, upper in band and lower < 0 gives 1101.
  - upper ≥ near gives 1011.
  - split < 0, upper ≥ 0 and lower in band gives 1011.
  - upper < −near gives 0111.
  - split < 0, upper < 0 and lower in band gives 0111.
- R6: When no row of R4 or R5 matches, the pattern is chosen by signs. For a count of 1: split ≥ 0 picks from cells 1/2 by the sign of upper (≥0 gives 1000, else 0100), and split < 0 picks from cells 3/4 by the sign of lower (≥0 gives 0010, else 0001). For a count of 3: split ≥ 0 drops a cell from 3/4 (lower ≥0 gives 1110, else 1101), and split < 0 drops a cell from 1/2 (upper ≥0 gives 1011, else 0111).
- R7: Step n is the interval after the n-th edge. Let P(n) be the pattern chosen in step n, with sequences S11 = c1−c2, S12 = c3−c4 and S21 = (c1+c2)−(c3+c4). Each loop then obeys A(n) = sat(S(n−2) − A(n−2)) and V(n) = sat(−A(n−2) − V(n−2)), with all history zero after reset. Here V is `loop_split`, `loop_upper` or `loop_lower` for S21, S11 and S12.
- R8: Every filter value saturates to the range −32..31 instead of wrapping.
- R9: While reset is asserted, `cell_sel` is 0000 and all three loop outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_count | input | 3 | Number of cells to turn on (5..7 clamp to 4) |
| thr_near | input | 6 | Signed inner threshold (best between 8 and 12) |
| thr_far | input | 6 | Signed outer threshold on the split loop |
| cell_sel | output | 4 | Registered cell selects, bit 3 = cell 1 |
| loop_split | output | 6 | Signed output of the between-pairs loop |
| loop_upper | output | 6 | Signed output of the cells 1/2 loop |
| loop_lower | output | 6 | Signed output of the cells 3/4 loop |

## Verification
The bench keeps its own model of the three resonator cascades and recomputes the table from the modelled filter values every step. It covers long runs of a single count, which drive the loops into saturation, and a zero inner threshold, which empties the band and forces the sign fallback. A design that wraps instead of clipping, swaps an upper/lower comparison, breaks the row priority or slips the latency by a cycle produces a pattern or a loop value different from the model within a few steps. Counts of 5 to 7 check that the clamp yields four cells and not a wrapped count.

// File: rtl/esb_pkg.sv
package esb_pkg;

    localparam int CELLS = 4;
    localparam int SEQ_W = 3;

    typedef enum logic [2:0] {
        CNT_NONE,
        CNT_ONE,
        CNT_TWO,
        CNT_THREE,
        CNT_ALL
    } cnt_class_e;

    function automatic cnt_class_e classify(input logic [2:0] cnt);
        cnt_class_e c;
        unique case (cnt)
            3'd0:    c = CNT_NONE;
            3'd1:    c = CNT_ONE;
            3'd2:    c = CNT_TWO;
            3'd3:    c = CNT_THREE;
            default: c = CNT_ALL;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/esb_resonator.sv
module esb_resonator #(
    parameter int W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] in_val,
    output logic signed [W-1:0] out_val
);
    localparam int SW = W + 2;
    localparam logic signed [SW-1:0] HI = SW'((2 ** (W - 1)) - 1);
    localparam logic signed [SW-1:0] LO = -SW'(2 ** (W - 1));

    logic signed [W-1:0]  in_d1, in_d2, out_d1, out_d2;
    logic signed [SW-1:0] ext_in, ext_out, raw;

    always_comb begin
        ext_in  = {{2{in_d2[W-1]}}, in_d2};
        ext_out = {{2{out_d2[W-1]}}, out_d2};
        raw     = -ext_in - ext_out;
        if (raw > HI)
            out_val = HI[W-1:0];
        else if (raw < LO)
            out_val = LO[W-1:0];
        else
            out_val = raw[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_d1  <= '0;
            in_d2  <= '0;
            out_d1 <= '0;
            out_d2 <= '0;
        end else begin
            in_d1  <= in_val;
            in_d2  <= in_d1;
            out_d1 <= out_val;
            out_d2 <= out_d1;
        end
    end
endmodule

// File: rtl/esb_loop.sv
module esb_loop #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic signed [esb_pkg::SEQ_W-1:0]  seq,
    output logic signed [W-1:0]               level
);
    localparam int QW = esb_pkg::SEQ_W;

    logic signed [QW-1:0] neg_seq;
    logic signed [W-1:0]  chain [STAGES+1];

    always_comb begin
        neg_seq  = -seq;
        chain[0] = {{(W-QW){neg_seq[QW-1]}}, neg_seq};
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        esb_resonator #(.W(W)) u_res (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_val (chain[g]),
            .out_val(chain[g+1])
        );
    end

    assign level = chain[STAGES];
endmodule

// File: rtl/esb_decide.sv
module esb_decide #(
    parameter int W = 6,
    parameter int T = 6
) (
    input  esb_pkg::cnt_class_e  cls,
    input  logic signed [W-1:0]  v_split,
    input  logic signed [W-1:0]  v_upper,
    input  logic signed [W-1:0]  v_lower,
    input  logic signed [T-1:0]  t_near,
    input  logic signed [T-1:0]  t_far,
    output logic [3:0]           pattern
);
    import esb_pkg::*;
    localparam int CW = ((W > T) ? W : T) + 1;

    logic signed [CW-1:0] es, eu, el, pn, nn, pf, nf;
    logic s_pos, u_pos, l_pos;
    logic u_band, l_band;
    logic u_hi, u_lo, l_hi, l_lo, s_far_hi, s_far_lo, s_above_nfar;

    always_comb begin
        es = {{(CW-W){v_split[W-1]}}, v_split};
        eu = {{(CW-W){v_upper[W-1]}}, v_upper};
        el = {{(CW-W){v_lower[W-1]}}, v_lower};
        pn = {{(CW-T){t_near[T-1]}}, t_near};
        pf = {{(CW-T){t_far[T-1]}}, t_far};
        nn = -pn;
        nf = -pf;
        s_pos = !es[CW-1];
        u_pos = !eu[CW-1];
        l_pos = !el[CW-1];
        u_hi  = (eu >= pn);
        u_lo  = (eu < nn);
        l_hi  = (el >= pn);
        l_lo  = (el < nn);
        u_band = (eu >= nn) && (eu < pn);
        l_band = (el >= nn) && (el < pn);
        s_far_hi     = (es >= pf);
        s_far_lo     = (es < nf);
        s_above_nfar = (es >= nf);
    end

    always_comb begin
        pattern = 4'b0000;
        unique case (cls)
            CNT_NONE: pattern = 4'b0000;
            CNT_ALL:  pattern = 4'b1111;
            CNT_TWO: begin
                if (s_far_hi)
                    pattern = 4'b1100;
                else if (s_far_lo)
                    pattern = 4'b0011;
                else
                    pattern = {u_pos, !u_pos, l_pos, !l_pos};
            end
            CNT_ONE: begin
                if (s_above_nfar && u_hi)
                    pattern = 4'b1000;
                else if (s_pos && u_pos && l_band)
                    pattern = 4'b1000;
                else if (s_far_lo && u_lo)
                    pattern = 4'b0100;
                else if (s_pos && !u_pos && l_band)
                    pattern = 4'b0100;
                else if (u_band && l_hi)
                    pattern = 4'b0010;
                else if (!s_pos && u_band && l_pos)
                    pattern = 4'b0010;
                else if (u_band && l_lo)
                    pattern = 4'b0001;
                else if (!s_pos && u_band && !l_pos)
                    pattern = 4'b0001;
                else if (s_pos)
                    pattern = u_pos ? 4'b1000 : 4'b0100;
                else
                    pattern = l_pos ? 4'b0010 : 4'b0001;
            end
            CNT_THREE: begin
                if (u_band && l_hi)
                    pattern = 4'b1110;
                else if (s_pos && u_band && l_pos)
                    pattern = 4'b1110;
                else if (u_band && l_lo)
                    pattern = 4'b1101;
                else if (s_pos && u_band && !l_pos)
                    pattern = 4'b1101;
                else if (u_hi)
                    pattern = 4'b1011;
                else if (!s_pos && u_pos && l_band)
                    pattern = 4'b1011;
                else if (u_lo)
                    pattern = 4'b0111;
                else if (!s_pos && !u_pos && l_band)
                    pattern = 4'b0111;
                else if (s_pos)
                    pattern = l_pos ? 4'b1110 : 4'b1101;
                else
                    pattern = u_pos ? 4'b1011 : 4'b0111;
            end
            default: pattern = 4'b0000;
        endcase
    end
endmodule

// File: rtl/esb_four_cell.sv
module esb_four_cell #(
    parameter int ACC_W  = 6,
    parameter int THR_W  = 6,
    parameter int STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              cell_count,
    input  logic signed [THR_W-1:0] thr_near,
    input  logic signed [THR_W-1:0] thr_far,
    output logic [3:0]              cell_sel,
    output logic signed [ACC_W-1:0] loop_split,
    output logic signed [ACC_W-1:0] loop_upper,
    output logic signed [ACC_W-1:0] loop_lower
);
    import esb_pkg::*;
    localparam int NLOOP = 3;

    cnt_class_e              cls;
    logic [3:0]              next_sel;
    logic signed [SEQ_W-1:0] seq   [NLOOP];
    logic signed [ACC_W-1:0] level [NLOOP];

    assign cls = classify(cell_count);

    esb_decide #(.W(ACC_W), .T(THR_W)) u_decide (
        .cls    (cls),
        .v_split(level[0]),
        .v_upper(level[1]),
        .v_lower(level[2]),
        .t_near (thr_near),
        .t_far  (thr_far),
        .pattern(next_sel)
    );

    always_comb begin
        seq[0] = SEQ_W'(next_sel[3]) + SEQ_W'(next_sel[2])
               - SEQ_W'(next_sel[1]) - SEQ_W'(next_sel[0]);
        seq[1] = SEQ_W'(next_sel[3]) - SEQ_W'(next_sel[2]);
        seq[2] = SEQ_W'(next_sel[1]) - SEQ_W'(next_sel[0]);
    end

    for (genvar k = 0; k < NLOOP; k++) begin : g_loop
        esb_loop #(.W(ACC_W), .STAGES(STAGES)) u_loop (
            .clk  (clk),
            .rst_n(rst_n),
            .seq  (seq[k]),
            .level(level[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cell_sel <= 4'b0000;
        else
            cell_sel <= next_sel;
    end

    assign loop_split = level[0];
    assign loop_upper = level[1];
    assign loop_lower = level[2];
endmodule

// File: rtl/esb_four_cell_chk.sv
module esb_four_cell_chk #(
    parameter int ACC_W = 6,
    parameter int THR_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              cell_count,
    input logic signed [THR_W-1:0] thr_far,
    input logic [3:0]              cell_sel,
    input logic signed [ACC_W-1:0] loop_split
);
    localparam int CW = ((ACC_W > THR_W) ? ACC_W : THR_W) + 1;

    logic seen;
    logic signed [CW-1:0] es, pf, nf;
    logic [2:0] want;

    always_comb begin
        es   = {{(CW-ACC_W){loop_split[ACC_W-1]}}, loop_split};
        pf   = {{(CW-THR_W){thr_far[THR_W-1]}}, thr_far};
        nf   = -pf;
        want = (cell_count > 3'd4) ? 3'd4 : cell_count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_ones_match: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> ($countones(cell_sel) == int'($past(want))));

    a_r2_none: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(cell_count) == 3'd0) |-> (cell_sel == 4'b0000));

    a_r2_all: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(cell_count) >= 3'd4) |-> (cell_sel == 4'b1111));

    a_r3_far_high: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(cell_count) == 3'd2 && $past(es >= pf)) |-> (cell_sel == 4'b1100));

    a_r3_far_low: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(cell_count) == 3'd2 && $past(es < nf) && $past(es < pf))
        |-> (cell_sel == 4'b0011));

    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (cell_sel == 4'b0000));
endmodule

bind esb_four_cell esb_four_cell_chk #(.ACC_W(ACC_W), .THR_W(THR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_count(cell_count),
    .thr_far   (thr_far),
    .cell_sel  (cell_sel),
    .loop_split(loop_split)
);

// File: tb/esb_four_cell_tb.sv
module esb_four_cell_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cell_count = 3'd0;
    logic signed [5:0] thr_near = 6'sd8;
    logic signed [5:0] thr_far  = 6'sd8;
    logic [3:0]        cell_sel;
    logic signed [5:0] loop_split, loop_upper, loop_lower;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    esb_four_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cell_count(cell_count),
        .thr_near(thr_near), .thr_far(thr_far), .cell_sel(cell_sel),
        .loop_split(loop_split), .loop_upper(loop_upper), .loop_lower(loop_lower)
    );

    int sd1[3], sd2[3], ad1[3], ad2[3], vd1[3], vd2[3];
    logic [3:0] pend;
    int pend_cnt;
    string pend_tag;
    bit pend_v;
    int lfsr = 32'h1ACE5;
    int fallbacks = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int x);
        if (x > 31) return 31;
        if (x < -32) return -32;
        return x;
    endfunction

    function automatic bit inb(input int v, input int t);
        return (v >= -t) && (v < t);
    endfunction

    // Reference table from R2..R6; fb reports a fallback pick (R6)
    function automatic logic [3:0] ref_pat(input int y, input int s, input int u, input int l,
                                           input int n, input int f, output bit fb);
        fb = 0;
        if (y == 0) return 4'b0000;
        if (y >= 4) return 4'b1111;
        if (y == 2) begin
            if (s >= f) return 4'b1100;
            if (s < -f) return 4'b0011;
            return {u >= 0, u < 0, l >= 0, l < 0};
        end
        if (y == 1) begin
            if (s >= -f && u >= n) return 4'b1000;
            if (s >= 0 && u >= 0 && inb(l, n)) return 4'b1000;
            if (s < -f && u < -n) return 4'b0100;
            if (s >= 0 && u < 0 && inb(l, n)) return 4'b0100;
            if (inb(u, n) && l >= n) return 4'b0010;
            if (s < 0 && inb(u, n) && l >= 0) return 4'b0010;
            if (inb(u, n) && l < -n) return 4'b0001;
            if (s < 0 && inb(u, n) && l < 0) return 4'b0001;
            fb = 1;
            if (s >= 0) return (u >= 0) ? 4'b1000 : 4'b0100;
            return (l >= 0) ? 4'b0010 : 4'b0001;
        end
        if (inb(u, n) && l >= n) return 4'b1110;
        if (s >= 0 && inb(u, n) && l >= 0) return 4'b1110;
        if (inb(u, n) && l < -n) return 4'b1101;
        if (s >= 0 && inb(u, n) && l < 0) return 4'b1101;
        if (u >= n) return 4'b1011;
        if (s < 0 && u >= 0 && inb(l, n)) return 4'b1011;
        if (u < -n) return 4'b0111;
        if (s < 0 && u < 0 && inb(l, n)) return 4'b0111;
        fb = 1;
        if (s >= 0) return (l >= 0) ? 4'b1110 : 4'b1101;
        return (u >= 0) ? 4'b1011 : 4'b0111;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 3; k++) begin
            sd1[k] = 0; sd2[k] = 0; ad1[k] = 0; ad2[k] = 0; vd1[k] = 0; vd2[k] = 0;
        end
        pend_v = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cell_count = 3'd0;
        model_clear();
        repeat (2) @(negedge clk);
        check(cell_sel == 4'b0000, "R9 sel", int'(cell_sel), 0);
        check(loop_split == 0 && loop_upper == 0 && loop_lower == 0,
              "R9 loops", int'(loop_split), 0);
        rst_n = 1'b1;
    endtask

    task automatic step(input int yv);
        int a_n[3], v_n[3], dut_v[3];
        bit clipped[3];
        bit fb;
        logic [3:0] e;
        int s_seq[3];
        int yc;
        @(negedge clk);
        if (pend_v) begin
            check($countones(cell_sel) == pend_cnt, "R1 ones", $countones(cell_sel), pend_cnt);
            check(cell_sel == pend, pend_tag, int'(cell_sel), int'(pend));
        end
        dut_v[0] = int'(loop_split);
        dut_v[1] = int'(loop_upper);
        dut_v[2] = int'(loop_lower);
        for (int k = 0; k < 3; k++) begin
            a_n[k] = sat(sd2[k] - ad2[k]);
            v_n[k] = sat(-ad2[k] - vd2[k]);
            clipped[k] = (a_n[k] != sd2[k] - ad2[k]) || (v_n[k] != -ad2[k] - vd2[k]);
            check(dut_v[k] == v_n[k], clipped[k] ? "R8 saturated loop" : "R7 loop",
                  dut_v[k], v_n[k]);
        end
        cell_count = yv[2:0];
        yc = yv & 7;
        e = ref_pat(yc, v_n[0], v_n[1], v_n[2], int'(thr_near), int'(thr_far), fb);
        if (fb) fallbacks++;
        pend = e;
        pend_cnt = (yc > 4) ? 4 : yc;
        pend_v = 1;
        if (yc == 0 || yc >= 4) pend_tag = "R2 pattern";
        else if (yc == 2) pend_tag = "R3 pattern";
        else if (fb) pend_tag = "R6 fallback";
        else if (yc == 1) pend_tag = "R4 pattern";
        else pend_tag = "R5 pattern";
        s_seq[0] = int'(e[3]) + int'(e[2]) - int'(e[1]) - int'(e[0]);
        s_seq[1] = int'(e[3]) - int'(e[2]);
        s_seq[2] = int'(e[1]) - int'(e[0]);
        for (int k = 0; k < 3; k++) begin
            sd2[k] = sd1[k]; sd1[k] = s_seq[k];
            ad2[k] = ad1[k]; ad1[k] = a_n[k];
            vd2[k] = vd1[k]; vd1[k] = v_n[k];
        end
    endtask

    task automatic run_config(input int n, input int f);
        thr_near = 6'(n);
        thr_far  = 6'(f);
        do_reset();
        for (int i = 0; i < 40; i++) step(2);
        for (int i = 0; i < 40; i++) step(1);
        for (int i = 0; i < 40; i++) step(3);
        for (int i = 0; i < 60; i++) step((i % 2 == 0) ? 1 : 3);
        for (int i = 0; i < 10; i++) step((i % 2 == 0) ? 0 : 4);
        for (int i = 0; i < 250; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >>> 17);
            lfsr = lfsr ^ (lfsr << 5);
            step(lfsr & 7);
        end
        for (int i = 0; i < 30; i++) step(2);
        step(0);
    endtask

    initial begin
        run_config(8, 8);
        run_config(12, 4);
        run_config(10, 16);
        run_config(0, 0);
        run_config(9, -6);
        run_config(31, 31);
        run_config(-3, 2);
        @(negedge clk);
        check(cell_sel == 4'b0000, "R2 final", int'(cell_sel), 0);
        $display("fallback picks seen: %0d", fallbacks);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule